// File: doc/BRIEF.md
# Set-Only Gated Register Transfer Datapath

This block models a 16-bit datapath of three registers: a buffer register B, a data register D and an accumulator A. The only way to load any of them is a set-only gate. A gate pulse turns on each destination bit whose source bit is 1 and leaves every other bit as it was. Each register also has its own clear strobe, which returns all of its bits to zero at once. A destination that was not cleared before a gate therefore ends up holding the OR of its old value and the source.

A pulse on `start` runs an I/O sense phase of six sub-cycles. The sequencer clears B and then gates the true-sense value of the active-low device bus into B. It clears D and gates B into D. It then clears A and loads A from D through a pass-through ALU path. The block pulses `done` for one cycle when A has been loaded. While idle, B can also be reloaded from a memory-read port, and that reload leaves D and A untouched.

Three fault-injection inputs, one per register, each suppress that register's clear. With a clear suppressed, the stale-contents OR behaviour can be reproduced on purpose.

Top module: `sense_xfer_path`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block sets `reg_b`, `reg_d` and `reg_a` to 0x0000 and `busy` and `done` to 0.
- R2: A `start` seen high at an idle edge (edge 0) makes `busy` 1 from edge 0. `done` is 1 for exactly the one cycle after edge 6, and at that point `busy` is back to 0.
- R3: The I/O bus is active-low: bit i of `io_bus_n` at 0 presents a logical 1. B takes the inverse of `io_bus_n` as sampled at edge 2 only. Bus changes after edge 2 do not affect B, D or A.
- R4: With no clear inhibited, after `done` the three registers `reg_b`, `reg_d` and `reg_a` all equal the inverse of the sampled bus value.
- R5: With `inh_clr_d` high, D becomes its old value ORed with B. Example: old D 0x3C00 gated with B 0x0800 stays 0x3C00, and then gated with B 0x00F0 becomes 0x3CF0.
- R6: With `inh_clr_b` high, B becomes its old value ORed with the inverted bus.
- R7: With `inh_clr_a` high, A becomes its old value ORed with D.
- R8: A `mem_load` high at an idle edge makes B equal `mem_data` after that edge and leaves D and A unchanged. If `inh_clr_b` is also high, B becomes its old value ORed with `mem_data`.
- R9: A `start` or a `mem_load` that arrives while `busy` is 1 is ignored. The running sequence ends at its own edge 6 with a single `done` pulse, and B keeps the bus value.
- R10: While idle with no `mem_load`, all registers hold their values. In particular, A keeps its value until the next sequence loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run one sense phase |
| io_bus_n | input | 16 | Device bus, active-low (0 = logical 1) |
| mem_load | input | 1 | Memory-read strobe that reloads B while idle |
| mem_data | input | 16 | Memory-read data word |
| inh_clr_b | input | 1 | Fault injection: suppress the B clear |
| inh_clr_d | input | 1 | Fault injection: suppress the D clear |
| inh_clr_a | input | 1 | Fault injection: suppress the A clear |
| reg_b | output | 16 | B register contents |
| reg_d | output | 16 | D register contents |
| reg_a | output | 16 | Accumulator contents |
| busy | output | 1 | Sense phase in progress |
| done | output | 1 | One-cycle pulse: A has been loaded |

## Verification
Edge 0 is the edge that accepts `start`. Counting from it, `busy` is due after edge 0, the bus is sampled at edge 2, and `done` and the final register values are due after edge 6. Each scenario task counts clock edges from the accepting edge and samples at the falling edge that follows the edge where a result is due.

The checks confirm that `done` stays low for edges 1 to 5 and falls again one cycle after it rises. To show that late bus changes are ignored, the bench changes the bus right after edge 2. It injects `start` and `mem_load` in the middle of a sequence to show those are ignored too.

// File: rtl/setgate_pkg.sv
// Package: shared phase encoding and per-sub-cycle control strobes for the
// set-only transfer datapath. Assumes one strobe active per sub-cycle.
package setgate_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CLR_B = 3'd1,
        PH_GT_B  = 3'd2,
        PH_CLR_D = 3'd3,
        PH_GT_D  = 3'd4,
        PH_CLR_A = 3'd5,
        PH_LD_A  = 3'd6
    } phase_t;

    typedef struct packed {
        logic clr_b;
        logic gate_b;
        logic clr_d;
        logic gate_d;
        logic clr_a;
        logic load_a;
    } xfer_ctl_t;

endpackage

// File: rtl/setonly_reg.sv
// Module: register loaded only by set-only gating.
// A gate ORs the source into the register; a separate clear zeroes every bit.
// When clear and gate coincide, the clear acts first and the gate then sets bits.
// Assumes a synchronous active-low reset.
module setonly_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             gate,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] q
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Per-bit flip-flop: only a clear resets, only a set-pulse with source 1 sets.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= 1'b0;
                else if (gate && src[i])
                    q[i] <= 1'b1;
                else if (clr)
                    q[i] <= 1'b0;
            end
        end
    endgenerate

    AST_NO_BIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q))); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !gate) |=> (q == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !gate) |=> $stable(q)); // R10

endmodule

// File: rtl/xfer_sequencer.sv
// Module: six-sub-cycle sequencer for the I/O sense phase.
// Steps: clear B, gate bus to B, clear D, gate B to D, clear A, load A.
// A start is only accepted while idle; done pulses once after the A load.
module xfer_sequencer
    import setgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    output xfer_ctl_t ctl,
    output logic      busy,
    output logic      done
);

    phase_t phase, phase_nx;

    // Next-phase selection: a fixed walk through the sub-cycles, then back to idle.
    always_comb begin
        unique case (phase)
            PH_IDLE:  phase_nx = start ? PH_CLR_B : PH_IDLE;
            PH_CLR_B: phase_nx = PH_GT_B;
            PH_GT_B:  phase_nx = PH_CLR_D;
            PH_CLR_D: phase_nx = PH_GT_D;
            PH_GT_D:  phase_nx = PH_CLR_A;
            PH_CLR_A: phase_nx = PH_LD_A;
            PH_LD_A:  phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    // Phase register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= phase_nx;
            done  <= (phase == PH_LD_A);
        end
    end

    // Strobe decode for the current sub-cycle.
    always_comb begin
        ctl        = '0;
        ctl.clr_b  = (phase == PH_CLR_B);
        ctl.gate_b = (phase == PH_GT_B);
        ctl.clr_d  = (phase == PH_CLR_D);
        ctl.gate_d = (phase == PH_GT_D);
        ctl.clr_a  = (phase == PH_CLR_A);
        ctl.load_a = (phase == PH_LD_A);
    end

    assign busy = (phase != PH_IDLE);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl)); // R2

    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.load_a |=> (done && !busy)); // R2

    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl.load_a) |=> busy); // R9

endmodule

// File: rtl/alu_pass.sv
// Module: ALU data path toward the accumulator, configured as a pass-through.
// Assumes purely combinational use; the A register captures its output.
module alu_pass #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] res
);

    // Pass-through function: result equals the D operand.
    always_comb res = opnd;

endmodule

// File: rtl/sense_xfer_path.sv
// Module: top of the set-only gated B/D/A transfer datapath.
// Inverts the active-low device bus and routes the sequencer strobes to the
// registers. Fault-injection inputs suppress individual clears. A memory read
// reloads B only while idle. Assumes a synchronous active-low reset.
module sense_xfer_path
    import setgate_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] io_bus_n,
    input  logic             mem_load,
    input  logic [WIDTH-1:0] mem_data,
    input  logic             inh_clr_b,
    input  logic             inh_clr_d,
    input  logic             inh_clr_a,
    output logic [WIDTH-1:0] reg_b,
    output logic [WIDTH-1:0] reg_d,
    output logic [WIDTH-1:0] reg_a,
    output logic             busy,
    output logic             done
);

    xfer_ctl_t        ctl;
    logic [WIDTH-1:0] bus_true;
    logic [WIDTH-1:0] b_src;
    logic [WIDTH-1:0] alu_out;
    logic             mem_take;
    logic             b_clr, b_gate, d_clr, a_clr;

    xfer_sequencer u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    // Bus polarity and B-source steering: a bus gate takes the sequence path, otherwise memory.
    always_comb begin
        bus_true = ~io_bus_n;
        mem_take = mem_load && !busy;
        b_src    = ctl.gate_b ? bus_true : mem_data;
        b_clr    = (ctl.clr_b || mem_take) && !inh_clr_b;
        b_gate   = ctl.gate_b || mem_take;
        d_clr    = ctl.clr_d && !inh_clr_d;
        a_clr    = ctl.clr_a && !inh_clr_a;
    end

    setonly_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk (clk), .rst_n (rst_n), .clr (b_clr), .gate (b_gate),
        .src (b_src), .q (reg_b)
    );

    setonly_reg #(.WIDTH(WIDTH)) u_reg_d (
        .clk (clk), .rst_n (rst_n), .clr (d_clr), .gate (ctl.gate_d),
        .src (reg_b), .q (reg_d)
    );

    alu_pass #(.WIDTH(WIDTH)) u_alu (
        .opnd (reg_d),
        .res  (alu_out)
    );

    setonly_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk (clk), .rst_n (rst_n), .clr (a_clr), .gate (ctl.load_a),
        .src (alu_out), .q (reg_a)
    );

    AST_A_COVERS_D: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((reg_a & reg_d) == reg_d)); // R7

    AST_D_COVERS_B: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.clr_a |-> ((reg_d & reg_b) == reg_b)); // R5

    AST_BUSY_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl.clr_b && !ctl.gate_b) |=> $stable(reg_b)); // R9

    AST_MEM_SPARES_DA: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(reg_d) && $stable(reg_a))); // R8

endmodule

// File: tb/sim_sense_xfer_path.sv
// Bench: directed scenario tasks for the set-only transfer datapath.
module sim_sense_xfer_path;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [W-1:0] io_bus_n;
    logic         mem_load;
    logic [W-1:0] mem_data;
    logic         inh_clr_b, inh_clr_d, inh_clr_a;
    logic [W-1:0] reg_b, reg_d, reg_a;
    logic         busy, done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    sense_xfer_path #(.WIDTH(W)) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .io_bus_n (io_bus_n),
        .mem_load (mem_load), .mem_data (mem_data),
        .inh_clr_b (inh_clr_b), .inh_clr_d (inh_clr_d), .inh_clr_a (inh_clr_a),
        .reg_b (reg_b), .reg_d (reg_d), .reg_a (reg_a),
        .busy (busy), .done (done)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Runs one sense phase. The bus is scrambled right after edge 2 when asked.
    // The task returns at the falling edge after edge 6.
    task automatic run_sense(input logic [W-1:0] sense, input bit scramble,
                             input bit poke_busy);
        @(negedge clk);
        io_bus_n = ~sense;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after accept", {15'd0, busy}, 16'd1);
        for (int e = 1; e <= 5; e++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2 no early done", {15'd0, done}, 16'd0);
            if (e == 2 && scramble) io_bus_n = ~16'hFFFF;
            if (e == 3 && poke_busy) begin
                start    = 1'b1;
                mem_load = 1'b1;
                mem_data = 16'hA5A5;
            end
            if (e == 4) begin
                start    = 1'b0;
                mem_load = 1'b0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2 done after edge 6", {15'd0, done}, 16'd1);
        chk("R2 idle at done", {15'd0, busy}, 16'd0);
    endtask

    task automatic done_falls();
        @(posedge clk);
        @(negedge clk);
        chk("R2 done one cycle", {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 reset B", reg_b, 16'h0000);
        chk("R1 reset D", reg_d, 16'h0000);
        chk("R1 reset A", reg_a, 16'h0000);
        chk("R1 reset busy/done", {14'd0, busy, done}, 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        run_sense(16'h3C00, 1'b1, 1'b0);
        chk("R3 B from inverted bus", reg_b, 16'h3C00);
        chk("R4 D equals bus", reg_d, 16'h3C00);
        chk("R4 A equals bus", reg_a, 16'h3C00);
        done_falls();
    endtask

    task automatic t_d_or();
        inh_clr_d = 1'b1;
        run_sense(16'h0800, 1'b0, 1'b0);
        chk("R5 B new value", reg_b, 16'h0800);
        chk("R5 D stale OR 0800", reg_d, 16'h3C00);
        chk("R5 A follows D", reg_a, 16'h3C00);
        run_sense(16'h00F0, 1'b0, 1'b0);
        chk("R5 D stale OR 00F0", reg_d, 16'h3CF0);
        chk("R5 A follows D 2", reg_a, 16'h3CF0);
        inh_clr_d = 1'b0;
    endtask

    task automatic t_b_or();
        inh_clr_b = 1'b1;
        run_sense(16'h0300, 1'b0, 1'b0);
        chk("R6 B stale OR bus", reg_b, 16'h03F0);
        chk("R6 D copies B", reg_d, 16'h03F0);
        inh_clr_b = 1'b0;
    endtask

    task automatic t_a_or();
        inh_clr_a = 1'b1;
        run_sense(16'h4001, 1'b0, 1'b0);
        chk("R7 D clean", reg_d, 16'h4001);
        chk("R7 A stale OR D", reg_a, 16'h43F1);
        inh_clr_a = 1'b0;
    endtask

    task automatic t_mem();
        @(negedge clk);
        inh_clr_b = 1'b1;
        mem_load  = 1'b1;
        mem_data  = 16'h0010;
        @(posedge clk);
        @(negedge clk);
        mem_load  = 1'b0;
        inh_clr_b = 1'b0;
        chk("R8 mem OR with clear inhibited", reg_b, 16'h4011);
        mem_load = 1'b1;
        mem_data = 16'h1234;
        @(posedge clk);
        @(negedge clk);
        mem_load = 1'b0;
        chk("R8 mem reload B", reg_b, 16'h1234);
        chk("R8 D untouched", reg_d, 16'h4001);
        chk("R8 A untouched", reg_a, 16'h43F1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 A held while idle", reg_a, 16'h43F1);
        chk("R10 B held while idle", reg_b, 16'h1234);
    endtask

    task automatic t_busy_ignore();
        run_sense(16'h0C0C, 1'b0, 1'b1);
        chk("R9 B keeps bus value", reg_b, 16'h0C0C);
        chk("R9 A result", reg_a, 16'h0C0C);
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9 no second done", {15'd0, done}, 16'd0);
            chk("R9 no restart", {15'd0, busy}, 16'd0);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        #80000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        start     = 1'b0;
        io_bus_n  = '1;
        mem_load  = 1'b0;
        mem_data  = '0;
        inh_clr_b = 1'b0;
        inh_clr_d = 1'b0;
        inh_clr_a = 1'b0;
        repeat (2) @(posedge clk);
        t_reset();
        t_basic();
        t_d_or();
        t_b_or();
        t_a_or();
        t_mem();
        t_busy_ignore();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule